// File: doc/BRIEF.md
# MII Duplex-Aware Carrier and Loopback Control

This block sits between the MAC-facing side of a media independent interface (MII) and the internal transmit and receive datapaths of a PHY. Data moves as 4-bit nibbles, one nibble per clock. On transmit, `mac_tx_en` acts as the valid qualifier. On receive, `mac_rx_dv` does the same. Neither direction has a ready signal and there is no back-pressure: the block accepts a nibble on every clock and presents one on every clock. The downstream consumer must take each receive nibble in the cycle it appears.

The carrier sense and collision outputs follow a duplex input. In half duplex, carrier reflects any transmit or receive activity, and collision flags cycles where both are active. In full duplex, carrier reflects only receive activity and collision stays low. A small register port holds a loopback enable. While loopback is on, MAC transmit nibbles return on the MAC receive outputs one clock later, the media receive path is ignored, and the media transmit side is held idle. A read-only status word reports whether loopback is active.

Top module: `mii_carrier_loop`

## Requirements
- R1: With `full_duplex` low, `mac_crs` is high in the cycle after any cycle where transmit activity (`mac_tx_en`) or receive activity is present, and low otherwise. Receive activity is `med_rx_dv`, or `mac_tx_en` in loopback.
- R2: With `full_duplex` high, `mac_crs` in the cycle after a cycle equals that cycle's receive activity only. Transmit activity alone never raises it.
- R3: With `full_duplex` high, `mac_col` stays low whatever the inputs.
- R4: The receive outputs (`mac_rxd`, `mac_rx_dv`, `mac_rx_er`) and the media transmit outputs take the same values for the same inputs in both duplex modes.
- R5: With loopback off, the receive outputs equal `med_rxd`/`med_rx_dv`/`med_rx_er` delayed by one clock. The media transmit outputs equal `mac_txd`/`mac_tx_en`/`mac_tx_er` delayed by one clock.
- R6: A write to address 0x00 sets loopback to bit 14 of the write data. Other bits of the write have no effect. A read of 0x00 returns loopback in bit 14 and zeros in all other bits. A write to any other address leaves loopback unchanged.
- R7: With loopback on, `mac_rxd`, `mac_rx_dv` and `mac_rx_er` equal `mac_txd`, `mac_tx_en` and `mac_tx_er` delayed by one clock. `med_rxd`, `med_rx_dv` and `med_rx_er` have no effect on any output.
- R8: While loopback is on, `med_tx_en` and `med_tx_er` are low and `med_txd` is zero.
- R9: A read of address 0x11 returns the loopback state in bit 3 and zeros in all other bits. Writes to 0x11 have no effect.
- R10: With `full_duplex` low and loopback off, `mac_col` is high in the cycle after a cycle with both `mac_tx_en` and `med_rx_dv` high, and low otherwise. In loopback, `mac_col` is low.
- R11: Clearing loopback switches the receive outputs back to the media path on the next clock. Reset clears loopback and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| mac_txd | input | NIB_W | Transmit nibble from the MAC |
| mac_tx_en | input | 1 | Transmit nibble valid |
| mac_tx_er | input | 1 | Transmit error qualifier |
| mac_rxd | output | NIB_W | Receive nibble to the MAC |
| mac_rx_dv | output | 1 | Receive nibble valid |
| mac_rx_er | output | 1 | Receive error qualifier |
| mac_crs | output | 1 | Carrier sense |
| mac_col | output | 1 | Collision |
| med_txd | output | NIB_W | Transmit nibble toward the media datapath |
| med_tx_en | output | 1 | Media transmit enable |
| med_tx_er | output | 1 | Media transmit error |
| med_rxd | input | NIB_W | Receive nibble from the media datapath |
| med_rx_dv | input | 1 | Media receive valid |
| med_rx_er | input | 1 | Media receive error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |

## Verification
The bench builds the block with its defaults: 4-bit nibbles, 5-bit register addresses, 16-bit register words, the control word at 0x00 and the status word at 0x11. With 4-bit nibbles, each vector can carry distinct patterns on the transmit and media-receive data. A wrong source selection or a stuck lane therefore shows up as a wrong value. The table covers each pairing of duplex and loopback with transmit-only, receive-only and overlapping activity. Directed tests then cover the loopback entry and exit boundary, register aliasing and reset taken while loopback is on.

// File: rtl/mii_cl_pkg.sv
package mii_cl_pkg;

  typedef enum logic {
    SRC_MEDIA = 1'b0,
    SRC_LOOP  = 1'b1
  } rx_src_e;

  function automatic logic carrier_of(input logic fdx, input logic tx_act,
                                      input logic rx_act);
    return fdx ? rx_act : (rx_act | tx_act);
  endfunction

  function automatic logic collision_of(input logic fdx, input rx_src_e src,
                                        input logic tx_act, input logic med_act);
    return (!fdx) && (src == SRC_MEDIA) && tx_act && med_act;
  endfunction

endpackage

// File: rtl/mii_cl_regs.sv
module mii_cl_regs #(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CTRL_ADDR     = 0,
  parameter int unsigned STAT_ADDR     = 17,
  parameter int unsigned LOOP_BIT      = 14,
  parameter int unsigned LOOP_STAT_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              loop_on
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic ctrl_hit;
  logic stat_hit;

  assign ctrl_hit = (reg_addr == CTRL_A);
  assign stat_hit = (reg_addr == STAT_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_on <= 1'b0;
    end else if (reg_wr && ctrl_hit) begin
      loop_on <= reg_wdata[LOOP_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) reg_rdata[LOOP_BIT]      = loop_on;
    if (stat_hit) reg_rdata[LOOP_STAT_BIT] = loop_on;
  end
endmodule

// File: rtl/mii_cl_rx_steer.sv
module mii_cl_rx_steer
  import mii_cl_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_on,
  input  logic [NIB_W-1:0] mac_txd,
  input  logic             mac_tx_en,
  input  logic             mac_tx_er,
  input  logic [NIB_W-1:0] med_rxd,
  input  logic             med_rx_dv,
  input  logic             med_rx_er,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output rx_src_e          src,
  output logic             rx_act
);
  assign src    = loop_on ? SRC_LOOP : SRC_MEDIA;
  assign rx_act = (src == SRC_LOOP) ? mac_tx_en : med_rx_dv;

  for (genvar b = 0; b < NIB_W; b++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= 1'b0;
      else        lane_q <= (src == SRC_LOOP) ? mac_txd[b] : med_rxd[b];
    end
    assign rxd[b] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
    end else begin
      rx_dv <= rx_act;
      rx_er <= (src == SRC_LOOP) ? mac_tx_er : med_rx_er;
    end
  end
endmodule

// File: rtl/mii_cl_tx_gate.sv
module mii_cl_tx_gate #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_on,
  input  logic [NIB_W-1:0] mac_txd,
  input  logic             mac_tx_en,
  input  logic             mac_tx_er,
  output logic [NIB_W-1:0] med_txd,
  output logic             med_tx_en,
  output logic             med_tx_er
);
  logic [NIB_W-1:0] txd_q;
  logic             en_q;
  logic             er_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= '0;
      en_q  <= 1'b0;
      er_q  <= 1'b0;
    end else begin
      txd_q <= loop_on ? '0 : mac_txd;
      en_q  <= mac_tx_en & ~loop_on;
      er_q  <= mac_tx_er & ~loop_on;
    end
  end

  assign med_txd   = loop_on ? '0 : txd_q;
  assign med_tx_en = en_q & ~loop_on;
  assign med_tx_er = er_q & ~loop_on;
endmodule

// File: rtl/mii_cl_carrier.sv
module mii_cl_carrier
  import mii_cl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    full_duplex,
  input  rx_src_e src,
  input  logic    mac_tx_en,
  input  logic    med_rx_dv,
  input  logic    rx_act,
  output logic    crs,
  output logic    col
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= carrier_of(full_duplex, mac_tx_en, rx_act);
      col <= collision_of(full_duplex, src, mac_tx_en, med_rx_dv);
    end
  end
endmodule

// File: rtl/mii_carrier_loop.sv
module mii_carrier_loop
  import mii_cl_pkg::*;
#(
  parameter int unsigned NIB_W         = 4,
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CTRL_ADDR     = 0,
  parameter int unsigned STAT_ADDR     = 17,
  parameter int unsigned LOOP_BIT      = 14,
  parameter int unsigned LOOP_STAT_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic [NIB_W-1:0]  mac_txd,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  output logic [NIB_W-1:0]  mac_rxd,
  output logic              mac_rx_dv,
  output logic              mac_rx_er,
  output logic              mac_crs,
  output logic              mac_col,
  output logic [NIB_W-1:0]  med_txd,
  output logic              med_tx_en,
  output logic              med_tx_er,
  input  logic [NIB_W-1:0]  med_rxd,
  input  logic              med_rx_dv,
  input  logic              med_rx_er,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic    loop_on;
  rx_src_e src;
  logic    rx_act;

  mii_cl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .LOOP_BIT(LOOP_BIT), .LOOP_STAT_BIT(LOOP_STAT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loop_on(loop_on)
  );

  mii_cl_rx_steer #(.NIB_W(NIB_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .loop_on(loop_on),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .med_rxd(med_rxd), .med_rx_dv(med_rx_dv), .med_rx_er(med_rx_er),
    .rxd(mac_rxd), .rx_dv(mac_rx_dv), .rx_er(mac_rx_er),
    .src(src), .rx_act(rx_act)
  );

  mii_cl_tx_gate #(.NIB_W(NIB_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .loop_on(loop_on),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .med_txd(med_txd), .med_tx_en(med_tx_en), .med_tx_er(med_tx_er)
  );

  mii_cl_carrier u_crs (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .src(src),
    .mac_tx_en(mac_tx_en), .med_rx_dv(med_rx_dv), .rx_act(rx_act),
    .crs(mac_crs), .col(mac_col)
  );
endmodule

// File: rtl/mii_carrier_loop_chk.sv
module mii_carrier_loop_chk #(
  parameter int unsigned NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_duplex,
  input logic             loop_on,
  input logic [NIB_W-1:0] mac_txd,
  input logic             mac_tx_en,
  input logic [NIB_W-1:0] mac_rxd,
  input logic             mac_rx_dv,
  input logic             mac_crs,
  input logic             mac_col,
  input logic [NIB_W-1:0] med_txd,
  input logic             med_tx_en,
  input logic             med_tx_er,
  input logic [NIB_W-1:0] med_rxd,
  input logic             med_rx_dv
);
  assert_hd_crs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(full_duplex) && $past(mac_tx_en)) |-> mac_crs);

  assert_fd_crs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(full_duplex) && !$past(loop_on))
      |-> (mac_crs == $past(med_rx_dv)));

  assert_fd_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full_duplex) |-> !mac_col);

  assert_norm_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(loop_on))
      |-> (mac_rx_dv == $past(med_rx_dv) && mac_rxd == $past(med_rxd)));

  assert_loop_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(loop_on))
      |-> (mac_rx_dv == $past(mac_tx_en) && mac_rxd == $past(mac_txd)));

  assert_media_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (!med_tx_en && !med_tx_er && med_txd == '0));

  assert_hd_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(full_duplex) && !$past(loop_on))
      |-> (mac_col == ($past(mac_tx_en) && $past(med_rx_dv))));
endmodule

bind mii_carrier_loop mii_carrier_loop_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .loop_on(loop_on),
  .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_rxd(mac_rxd),
  .mac_rx_dv(mac_rx_dv), .mac_crs(mac_crs), .mac_col(mac_col),
  .med_txd(med_txd), .med_tx_en(med_tx_en), .med_tx_er(med_tx_er),
  .med_rxd(med_rxd), .med_rx_dv(med_rx_dv)
);

// File: tb/mii_carrier_loop_test.sv
module mii_carrier_loop_test;
  localparam int NIB_W = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b0;
  logic [NIB_W-1:0] mac_txd = '0;
  logic mac_tx_en = 1'b0, mac_tx_er = 1'b0;
  logic [NIB_W-1:0] mac_rxd;
  logic mac_rx_dv, mac_rx_er, mac_crs, mac_col;
  logic [NIB_W-1:0] med_txd;
  logic med_tx_en, med_tx_er;
  logic [NIB_W-1:0] med_rxd = '0;
  logic med_rx_dv = 1'b0, med_rx_er = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mii_carrier_loop uut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv), .mac_rx_er(mac_rx_er),
    .mac_crs(mac_crs), .mac_col(mac_col),
    .med_txd(med_txd), .med_tx_en(med_tx_en), .med_tx_er(med_tx_er),
    .med_rxd(med_rxd), .med_rx_dv(med_rx_dv), .med_rx_er(med_rx_er),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // stimulus: fd loop txen txer txd[4] rxdv rxer rxd[4]
  // expected: crs col rxdv rxer rxd[4] medtxen medtxd[4]
  localparam logic [26:0] VEC [12] = '{
    27'b0_0_1_0_1010_0_0_0000_1_0_0_0_0000_1_1010, // R1 tx only
    27'b0_0_0_0_0000_1_0_0101_1_0_1_0_0101_0_0000, // R1 rx only
    27'b0_0_1_0_0011_1_0_1100_1_1_1_0_1100_1_0011, // R10 overlap
    27'b1_0_1_0_0011_1_0_1100_1_0_1_0_1100_1_0011, // R3 R4 same data, fd
    27'b1_0_1_0_1111_0_0_0000_0_0_0_0_0000_1_1111, // R2 tx only fd
    27'b1_0_0_0_0000_1_1_1001_1_0_1_1_1001_0_0000, // R5 rx error path
    27'b0_1_1_0_0110_1_0_1111_1_0_1_0_0110_0_0000, // R7 R8 hd loop
    27'b1_1_1_1_1110_1_0_0001_1_0_1_1_1110_0_0000, // R7 fd loop tx_er
    27'b1_1_0_0_0000_1_1_1011_0_0_0_0_0000_0_0000, // R7 media ignored
    27'b0_0_0_0_0000_0_0_0000_0_0_0_0_0000_0_0000, // R1 idle
    27'b0_1_0_0_0000_1_0_0111_0_0_0_0_0000_0_0000, // R7 hd loop idle
    27'b0_0_1_1_0001_0_0_0000_1_0_0_0_0000_1_0001  // R5 tx error
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] r;
    #22 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset outs", {28'd0, mac_crs, mac_col, mac_rx_dv, med_tx_en}, 32'd0);
    rd(A_CTRL, r); chk("R6 reset ctrl", 32'(r), 32'h0);
    rd(A_STAT, r); chk("R9 reset stat", 32'(r), 32'h0);

    foreach (VEC[i]) begin
      logic [26:0] v;
      v = VEC[i];
      wr(A_CTRL, v[25] ? 16'hFFFF : 16'hBFFF);
      full_duplex = v[26];
      mac_tx_en = v[24]; mac_tx_er = v[23]; mac_txd = v[22:19];
      med_rx_dv = v[18]; med_rx_er = v[17]; med_rxd = v[16:13];
      @(negedge clk);
      chk($sformatf("R1 R2 crs vec%0d", i), 32'(mac_crs), 32'(v[12]));
      chk($sformatf("R3 R10 col vec%0d", i), 32'(mac_col), 32'(v[11]));
      chk($sformatf("R4 R5 R7 rx vec%0d", i),
          32'({mac_rx_dv, mac_rx_er, mac_rxd}), 32'(v[10:5]));
      chk($sformatf("R5 R8 medtx vec%0d", i), 32'({med_tx_en, med_txd}), 32'(v[4:0]));
    end

    // R6 R9 register access
    wr(A_CTRL, 16'h4000);
    rd(A_CTRL, r); chk("R6 ctrl readback", 32'(r), 32'h4000);
    rd(A_STAT, r); chk("R9 stat readback", 32'(r), 32'h0008);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, r); chk("R9 stat write ignored", 32'(r), 32'h0008);
    wr(5'h03, 16'h0000);
    rd(A_STAT, r); chk("R6 other addr ignored", 32'(r), 32'h0008);

    // R7 single-cycle latency
    full_duplex = 1'b0;
    @(negedge clk);
    mac_tx_en = 1'b1; mac_txd = 4'h3; med_rx_dv = 1'b1; med_rxd = 4'hC;
    @(negedge clk);
    mac_tx_en = 1'b0; mac_txd = 4'h0;
    chk("R7 loop latency", 32'({mac_rx_dv, mac_rxd}), 32'h13);
    chk("R8 media idle", 32'({med_tx_en, med_tx_er, med_txd}), 32'h0);
    @(negedge clk);
    chk("R7 loop end", 32'(mac_rx_dv), 32'h0);

    // R11 loopback exit boundary
    mac_tx_en = 1'b1; mac_txd = 4'h5; med_rx_dv = 1'b1; med_rxd = 4'hA;
    @(negedge clk);
    chk("R7 before exit", 32'(mac_rxd), 32'h5);
    wr(A_CTRL, 16'h0000);
    chk("R11 exit edge still loop", 32'(mac_rxd), 32'h5);
    @(negedge clk);
    chk("R11 media path back", 32'({mac_rx_dv, mac_rxd}), 32'h1A);
    chk("R10 col after exit", 32'(mac_col), 32'h1);
    chk("R5 media tx after exit", 32'({med_tx_en, med_txd}), 32'h15);

    // R11 reset while loopback on
    wr(A_CTRL, 16'h4000);
    #2 rst_n = 1'b0;
    #3 rst_n = 1'b1;
    rd(A_STAT, r); chk("R11 reset clears loop", 32'(r), 32'h0);
    chk("R11 reset clears rx", 32'({mac_rx_dv, mac_crs}), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule